// File: doc/BRIEF.md
# Clock-Buffer PLL Mode Configuration Register

This block is the register slice that decides how the PLL of a managed clock buffer runs. A three-level bandwidth strap arrives already decoded as a two-bit level code. The block captures it while cold reset is held and keeps it for the whole power cycle. From that captured level it drives a mode select to the clock path: low-bandwidth PLL, PLL bypass or high-bandwidth PLL.

An SMBus slave front end reaches configuration byte 0 through a simple single-cycle byte port. The top two bits of the byte always report the captured strap, even after software has overridden the mode. Two override bits can only be written while an unlock bit is already set. The new mode reaches the clock path only at the next warm reset, which loads either the override or the captured strap.

A power-down input freezes the bus side: accesses are dropped and nothing programmed is lost. The block never stretches the bus clock and has no general-call handling. The bit-level protocol engine, the tri-level comparators and the PLL itself sit outside it.

Top module: `clkbuf_mode_cfg`

## Requirements
- R1: While `rst` is high at a clock edge, the strap level code is captured and `pll_mode` is loaded from it. Level 00 (low) gives mode 00 (low bandwidth), 01 (middle) gives 01 (bypass), 10 (high) gives 11 (high bandwidth), and the unused code 11 gives 01. `pll_mode` never shows 10.
- R2: A read (`acc_valid`=1, `acc_write`=0) of address 0 loads `rd_data` at that clock edge with byte 0. The fields are: bits 7:6 captured strap mode, bits 5:4 storage, bit 3 unlock, bits 2:1 override, bit 0 storage. A read of any other address loads 0. `rd_data` holds its value in every cycle without a read, and is 0 after reset.
- R3: Bits 7:6 are read-only and always return the strap mode captured at cold reset, whatever is written and after any warm reset.
- R4: A write to address 0 changes bits 2:1 only if bit 3 was already 1 before that write. A write that sets bit 3 does not unlock its own bits 2:1.
- R5: Bits 5:4, 3 and 0 are plain read/write bits. All writable bits reset to 0 on cold reset.
- R6: `pll_mode` changes only on cold or warm reset. A write alone never changes it.
- R7: At a clock edge with `warm_rst` high, `pll_mode` becomes the override bits if bit 3 is 1, with code 10 treated as 01. Otherwise it becomes the captured strap mode. The register contents are kept. A write in the same cycle is applied to the register, but the mode is chosen from the contents before that write.
- R8: While `pwr_down` is high, reads and writes are ignored. `rd_data` holds and the register contents are kept.
- R9: Writes to any address other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active high; strap is captured while high |
| warm_rst | input | 1 | Warm reset pulse, reloads the active PLL mode |
| strap_lvl | input | 2 | Decoded strap level: 00 low, 01 middle, 10 high |
| pwr_down | input | 1 | Power-down, freezes the access port |
| acc_valid | input | 1 | Access strobe from the SMBus front end |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pll_mode | output | 2 | Active PLL mode: 00 low bandwidth, 01 bypass, 11 high bandwidth |

## Verification
The properties assume that `rst` is held for at least one clock edge before anything is checked. They also assume that `warm_rst` is the only input meant to move the mode after reset. They put no limit on strap codes, so the illegal level 11 is driven on purpose. The stimulus applies each cold reset with a fixed strap code and keeps every access to a single cycle. It mixes power-down, warm reset and same-cycle writes freely, because the model defines their combined effect.

// File: rtl/clkbuf_cfg_pkg.sv
package clkbuf_cfg_pkg;

  localparam int BYTE_W = 8;

  // bit positions inside configuration byte 0
  localparam int B_STRAP_HI = 7;
  localparam int B_STRAP_LO = 6;
  localparam int B_SPARE_HI = 5;
  localparam int B_SPARE_LO = 4;
  localparam int B_UNLOCK   = 3;
  localparam int B_OVR_HI   = 2;
  localparam int B_OVR_LO   = 1;
  localparam int B_SPARE0   = 0;

  typedef enum logic [1:0] {
    MODE_LBW = 2'b00,
    MODE_BYP = 2'b01,
    MODE_HBW = 2'b11
  } pll_mode_e;

  // decoded strap level: 00 low, 01 middle, 10 high, 11 unused
  function automatic logic [1:0] level_to_mode(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return MODE_LBW;
      2'b10:   return MODE_HBW;
      default: return MODE_BYP;
    endcase
  endfunction

  function automatic logic [1:0] legal_mode(input logic [1:0] code);
    return (code == 2'b10) ? MODE_BYP : code;
  endfunction

endpackage

// File: rtl/clkbuf_strap_latch.sv
module clkbuf_strap_latch
  import clkbuf_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_lvl,
  output logic [1:0] strap_mode
);

  always_ff @(posedge clk) begin
    if (rst) strap_mode <= level_to_mode(strap_lvl);
  end

endmodule

// File: rtl/clkbuf_cfg_regs.sv
module clkbuf_cfg_regs
  import clkbuf_cfg_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  input  logic [1:0]        strap_mode,
  output logic [BYTE_W-1:0] rd_data,
  output logic              unlock_q,
  output logic [1:0]        ovr_q
);

  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CFG_ADDR);

  logic [1:0] spare_hi_q;
  logic       spare0_q;
  logic       live, hit, do_wr, do_rd;
  logic [BYTE_W-1:0] cur_byte;

  assign live  = acc_valid && !pwr_down;
  assign hit   = (acc_addr == SEL);
  assign do_wr = live && acc_write && hit;
  assign do_rd = live && !acc_write;

  always_comb begin
    cur_byte = '0;
    cur_byte[B_STRAP_HI:B_STRAP_LO] = strap_mode;
    cur_byte[B_SPARE_HI:B_SPARE_LO] = spare_hi_q;
    cur_byte[B_UNLOCK]              = unlock_q;
    cur_byte[B_OVR_HI:B_OVR_LO]     = ovr_q;
    cur_byte[B_SPARE0]              = spare0_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spare_hi_q <= '0;
      spare0_q   <= 1'b0;
      unlock_q   <= 1'b0;
      ovr_q      <= '0;
    end else if (do_wr) begin
      spare_hi_q <= acc_wdata[B_SPARE_HI:B_SPARE_LO];
      spare0_q   <= acc_wdata[B_SPARE0];
      unlock_q   <= acc_wdata[B_UNLOCK];
      if (unlock_q) ovr_q <= acc_wdata[B_OVR_HI:B_OVR_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= hit ? cur_byte : '0;
  end

endmodule

// File: rtl/clkbuf_mode_sel.sv
module clkbuf_mode_sel
  import clkbuf_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       warm_rst,
  input  logic [1:0] strap_lvl,
  input  logic [1:0] strap_mode,
  input  logic       unlock_q,
  input  logic [1:0] ovr_q,
  output logic [1:0] pll_mode
);

  always_ff @(posedge clk) begin
    if (rst)           pll_mode <= level_to_mode(strap_lvl);
    else if (warm_rst) pll_mode <= unlock_q ? legal_mode(ovr_q) : strap_mode;
  end

endmodule

// File: rtl/clkbuf_mode_cfg.sv
module clkbuf_mode_cfg
  import clkbuf_cfg_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic [1:0]        strap_lvl,
  input  logic              pwr_down,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        rd_data,
  output logic [1:0]        pll_mode
);

  logic [1:0] strap_mode;
  logic       unlock_q;
  logic [1:0] ovr_q;

  clkbuf_strap_latch u_strap (
    .clk        (clk),
    .rst        (rst),
    .strap_lvl  (strap_lvl),
    .strap_mode (strap_mode)
  );

  clkbuf_cfg_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .pwr_down   (pwr_down),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .strap_mode (strap_mode),
    .rd_data    (rd_data),
    .unlock_q   (unlock_q),
    .ovr_q      (ovr_q)
  );

  clkbuf_mode_sel u_mode (
    .clk        (clk),
    .rst        (rst),
    .warm_rst   (warm_rst),
    .strap_lvl  (strap_lvl),
    .strap_mode (strap_mode),
    .unlock_q   (unlock_q),
    .ovr_q      (ovr_q),
    .pll_mode   (pll_mode)
  );

endmodule

// File: rtl/clkbuf_mode_cfg_chk.sv
module clkbuf_mode_cfg_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              warm_rst,
  input logic              pwr_down,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        rd_data,
  input logic [1:0]        pll_mode,
  input logic              unlock_q,
  input logic [1:0]        ovr_q
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pll_mode != 2'b10);                                                // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || acc_write || pwr_down) |=> $stable(rd_data));      // R2

  AST_STRAP_FIELD: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] != 2'b10);                                            // R3

  AST_OVR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !unlock_q |=> $stable(ovr_q));                                     // R4

  AST_MODE_STILL: assert property (@(posedge clk) disable iff (rst)
    !warm_rst |=> $stable(pll_mode));                                  // R6

  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> ($stable(ovr_q) && $stable(unlock_q)));               // R8

endmodule

bind clkbuf_mode_cfg clkbuf_mode_cfg_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .warm_rst  (warm_rst),
  .pwr_down  (pwr_down),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .rd_data   (rd_data),
  .pll_mode  (pll_mode),
  .unlock_q  (unlock_q),
  .ovr_q     (ovr_q)
);

// File: tb/clkbuf_mode_cfg_tb.sv
`timescale 1ns/1ps
module clkbuf_mode_cfg_tb_top;

  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          warm_rst = 1'b0;
  logic [1:0]    strap_lvl = 2'b00;
  logic          pwr_down = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [7:0]    acc_wdata = '0;
  logic [7:0]    rd_data;
  logic [1:0]    pll_mode;

  always #4 clk = ~clk;

  clkbuf_mode_cfg #(.ADDR_W(AW), .CFG_ADDR(0)) dut_i (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .strap_lvl(strap_lvl),
    .pwr_down(pwr_down), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .pll_mode(pll_mode)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";

  // behavioural reference model
  logic [1:0] m_strap;
  logic [7:0] m_cfg;   // writable bits only, 7:6 kept at 0
  logic [1:0] m_mode;
  logic [7:0] m_rd;

  function automatic logic [1:0] lvl_mode(input logic [1:0] l);
    if (l == 2'b00) return 2'b00;
    if (l == 2'b10) return 2'b11;
    return 2'b01;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (rst) begin
      m_strap = lvl_mode(strap_lvl);
      m_mode  = m_strap;
      m_cfg   = 8'h00;
      m_rd    = 8'h00;
    end else begin
      nxt = m_cfg;
      if (warm_rst)
        m_mode = m_cfg[3] ? ((m_cfg[2:1] == 2'b10) ? 2'b01 : m_cfg[2:1]) : m_strap;
      if (acc_valid && !pwr_down) begin
        if (acc_write) begin
          if (acc_addr == 0) begin
            nxt[5:3] = acc_wdata[5:3];
            nxt[0]   = acc_wdata[0];
            if (m_cfg[3]) nxt[2:1] = acc_wdata[2:1];
          end
        end else begin
          m_rd = (acc_addr == 0) ? {m_strap, m_cfg[5:0]} : 8'h00;
        end
      end
      m_cfg = nxt;
    end
  end

  task automatic compare();
    n_chk++;
    if (rd_data !== m_rd || pll_mode !== m_mode) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h pll_mode=%b expected rd_data=%h pll_mode=%b",
               tag, rd_data, pll_mode, m_rd, m_mode);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at next negedge
  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [7:0] d, input logic pd, input logic wr);
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
    pwr_down = pd; warm_rst = wr;
    @(negedge clk);
    compare();
    acc_valid = 1'b0; warm_rst = 1'b0;
  endtask

  task automatic idle(); step(0, 0, '0, 8'h00, 0, 0); endtask
  task automatic wr0(input logic [7:0] d); step(1, 1, '0, d, 0, 0); endtask
  task automatic rd0(); step(1, 0, '0, 8'h00, 0, 0); endtask

  task automatic cold(input logic [1:0] lvl);
    rst = 1'b1; strap_lvl = lvl;
    step(0, 0, '0, 8'h00, 0, 0);
    step(0, 0, '0, 8'h00, 0, 0);
    rst = 1'b0; strap_lvl = ~lvl;   // later strap changes must not matter
    idle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    // R1: each level code, including the unused 11
    for (int l = 0; l < 4; l++) begin
      tag = "R1"; cold(2'(l));
      tag = "R5"; rd0();
    end
    // R3 / R4 / R5: locked write sets storage, override stays 00
    cold(2'b00);
    tag = "R4"; wr0(8'hFF); rd0();
    tag = "R3"; rd0();
    tag = "R4"; wr0(8'h0C); rd0();          // unlocked now: override 10
    tag = "R6"; idle(); idle();
    tag = "R7"; step(0, 0, '0, 8'h00, 0, 1); rd0();   // 10 -> bypass
    tag = "R4"; wr0(8'h0E); rd0();
    tag = "R7"; step(0, 0, '0, 8'h00, 0, 1); rd0();   // high bandwidth
    tag = "R3"; wr0(8'hC8); rd0();
    tag = "R5"; wr0(8'h31); rd0();          // clears unlock, override held
    tag = "R7"; step(0, 0, '0, 8'h00, 0, 1); rd0();   // back to strap
    // R7: same-cycle write and warm reset
    wr0(8'h08); wr0(8'h0A);
    tag = "R7"; step(1, 1, '0, 8'h06, 0, 1); rd0();
    step(0, 0, '0, 8'h00, 0, 1); rd0();
    // R8: power-down freezes
    wr0(8'h2C); rd0();
    tag = "R8"; step(1, 1, '0, 8'h13, 1, 0); step(1, 0, '0, 8'h00, 1, 0);
    step(1, 0, 3'd2, 8'h00, 1, 0); step(0, 0, '0, 8'h00, 0, 0); rd0();
    // R9 / R2: other addresses
    tag = "R9"; step(1, 1, 3'd1, 8'h17, 0, 0); step(1, 1, 3'd7, 8'h00, 0, 0); rd0();
    tag = "R2"; step(1, 0, 3'd5, 8'h00, 0, 0); idle(); rd0();
    // mixed traffic with high strap
    tag = "R2"; cold(2'b10);
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[1], lf[2], (lf[3] & lf[4]) ? AW'(lf[7:5]) : '0,
           {lf[8], lf[15:9]}, lf[11] & lf[12] & lf[13], lf[14] & lf[9] & lf[6]);
    end
    finish_run();
  end

endmodule